// File: doc/BRIEF.md
# Excluding random tag generator

This block picks a 4-bit allocation tag for a pointer. A 16-bit linear feedback shift register (the seed) and a 4-bit start tag sit together in a state word. A random request steps the register four times to form a 4-bit offset. It then walks forward from the start tag, modulo 16, and skips every tag value that the exclusion mask forbids. The chosen tag is returned and becomes the new start tag, and the advanced seed is stored beside it.

An add-offset request serves tag arithmetic. The walk starts from the pointer's own tag and uses an offset taken from the request. The shift register is left alone. The search is iterative: each clock cycle tests one candidate. A one-cycle `done` pulse delivers the result, and `busy` marks the walk in progress. A software write port loads the seed and the start tag directly.

Top module: `tagpick_unit`

## Requirements
- R1: After reset, `st_word` equals {RST_SEED, 4'b0, RST_START}, and both `busy` and `done` are low.
- R2: In random mode, each of the four register steps computes bit = s[5]^s[3]^s[2]^s[0] and sets s = {bit, s[15:1]}. The bit from step i becomes offset bit i, with step 0 giving the LSB.
- R3: In random mode, the exclusion mask is `req_excl | ctl_excl`. Bit k set forbids tag k, and the result is never a forbidden tag unless every tag is forbidden.
- R4: If all 16 tags are excluded, the result is 0 whatever the offset.
- R5: With offset 0, the result is the start tag if it is allowed. Otherwise it is the next allowed tag counting upward modulo 16.
- R6: With offset N>0, the walk repeats N times: advance by one modulo 16, then keep advancing while the tag is excluded.
- R7: After a random request, `st_word[3:0]` holds the result and `st_word[23:8]` holds the advanced seed. Both are visible in the cycle where `done` is high.
- R8: If the stored seed is zero and `ctl_reseed_en` is high, the seed value 1 is used in its place before stepping. With `ctl_reseed_en` low, a zero seed stays zero and gives offset 0.
- R9: In add mode (`req_add_mode`=1), the start is `req_tag`, the offset is `req_ofs`, and only `ctl_excl` applies. `req_excl` is ignored and `st_word` is unchanged.
- R10: A high `cfg_wr_en` loads `cfg_wr_seed` and `cfg_wr_start` into `st_word` at the next edge. In the same edge it takes priority over the write-back of a random request.
- R11: A request is taken only when `valid` is high and `busy` is low. Requests raised while busy are ignored. Each request gives exactly one `done` pulse, and each walk step tests at most 16 candidates, so an offset of 15 with a single allowed tag takes 240 busy cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_excl | input | 16 | Control exclusion mask, one bit per tag value |
| ctl_reseed_en | input | 1 | Allows a zero seed to be replaced by 1 |
| cfg_wr_en | input | 1 | Software write strobe for the state word |
| cfg_wr_seed | input | 16 | Seed value to write |
| cfg_wr_start | input | 4 | Start tag to write |
| req_valid | input | 1 | Request strobe |
| req_add_mode | input | 1 | 0: random tag, 1: add offset to pointer tag |
| req_excl | input | 16 | Per-request exclusion mask (random mode only) |
| req_tag | input | 4 | Pointer tag (add mode start) |
| req_ofs | input | 4 | Tag offset (add mode) |
| busy | output | 1 | Walk in progress; requests ignored |
| done | output | 1 | One-cycle pulse with a valid result |
| res_tag | output | 4 | Chosen tag |
| st_word | output | 24 | State word: seed in [23:8], start tag in [3:0] |

## Verification
A software write of the state word and the write-back at the end of a random walk can land on the same clock edge. The bench works out the walk length from its own model of the seed steps. It then raises `cfg_wr_en` in exactly the cycle before `done`. The result returned must still be the generated tag, while `st_word` must show the written seed and start tag rather than the generated ones.

// File: rtl/tagpick_pkg.sv
package tagpick_pkg;
  typedef enum logic {
    TP_RAND = 1'b0,
    TP_ADD  = 1'b1
  } tp_mode_e;

  // feedback taps of the 16-bit seed register
  localparam int TP_TAP0 = 0;
  localparam int TP_TAP1 = 2;
  localparam int TP_TAP2 = 3;
  localparam int TP_TAP3 = 5;
endpackage

// File: rtl/tagpick_lfsr.sv
module tagpick_lfsr #(
  parameter int SEED_W = 16,
  parameter int STEPS  = 4
) (
  input  logic [SEED_W-1:0] seed_in,
  output logic [SEED_W-1:0] seed_out,
  output logic [STEPS-1:0]  ofs
);
  import tagpick_pkg::*;

  logic [SEED_W-1:0] chain [STEPS+1];

  assign chain[0] = seed_in;

  for (genvar g = 0; g < STEPS; g++) begin : g_step
    logic fb;
    assign fb          = chain[g][TP_TAP3] ^ chain[g][TP_TAP2] ^
                         chain[g][TP_TAP1] ^ chain[g][TP_TAP0];
    assign chain[g+1]  = {fb, chain[g][SEED_W-1:1]};
    assign ofs[g]      = fb;
  end

  assign seed_out = chain[STEPS];
endmodule

// File: rtl/tagpick_walker.sv
module tagpick_walker #(
  parameter int TAG_W = 4,
  localparam int NTAGS = 1 << TAG_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [TAG_W-1:0] ld_tag,
  input  logic [TAG_W-1:0] ld_ofs,
  input  logic [NTAGS-1:0] ld_mask,
  output logic             busy,
  output logic             fin_now,
  output logic [TAG_W-1:0] tag_now,
  output logic             fin,
  output logic [TAG_W-1:0] fin_tag,
  output logic [NTAGS-1:0] cur_mask
);
  logic             busy_q, busy_d;
  logic             fin_q;
  logic [TAG_W-1:0] tag_q;
  logic [TAG_W-1:0] cand_q, cand_d;
  logic [TAG_W-1:0] steps_q, steps_d;
  logic [NTAGS-1:0] mask_q;
  logic [TAG_W-1:0] nxt;
  logic             cand_en;

  assign nxt = cand_q + 1'b1;

  always_comb begin
    busy_d  = busy_q;
    cand_d  = cand_q;
    steps_d = steps_q;
    fin_now = 1'b0;
    tag_now = '0;
    cand_en = 1'b0;
    if (load) begin
      busy_d  = 1'b1;
      cand_en = 1'b1;
      // offset 0 is one step taken from the tag just below the start
      if (ld_ofs == '0) begin
        cand_d  = ld_tag - 1'b1;
        steps_d = TAG_W'(1);
      end else begin
        cand_d  = ld_tag;
        steps_d = ld_ofs;
      end
    end else if (busy_q) begin
      if (&mask_q) begin
        busy_d  = 1'b0;
        fin_now = 1'b1;
      end else begin
        cand_en = 1'b1;
        cand_d  = nxt;
        if (!mask_q[nxt]) begin
          if (steps_q == TAG_W'(1)) begin
            busy_d  = 1'b0;
            fin_now = 1'b1;
            tag_now = nxt;
          end else begin
            steps_d = steps_q - 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      fin_q   <= 1'b0;
      tag_q   <= '0;
      cand_q  <= '0;
      steps_q <= '0;
      mask_q  <= '0;
    end else begin
      busy_q <= busy_d;
      fin_q  <= fin_now;
      if (fin_now) tag_q <= tag_now;
      if (cand_en) begin
        cand_q  <= cand_d;
        steps_q <= steps_d;
      end
      if (load) mask_q <= ld_mask;
    end
  end

  assign busy     = busy_q;
  assign fin      = fin_q;
  assign fin_tag  = tag_q;
  assign cur_mask = mask_q;
endmodule

// File: rtl/tagpick_unit.sv
module tagpick_unit #(
  parameter int          TAG_W     = 4,
  parameter int          SEED_W    = 16,
  parameter logic [15:0] RST_SEED  = 16'hACE1,
  parameter logic [3:0]  RST_START = 4'h0,
  localparam int         NTAGS     = 1 << TAG_W,
  localparam int         WORD_W    = SEED_W + 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NTAGS-1:0]  ctl_excl,
  input  logic              ctl_reseed_en,
  input  logic              cfg_wr_en,
  input  logic [SEED_W-1:0] cfg_wr_seed,
  input  logic [TAG_W-1:0]  cfg_wr_start,
  input  logic              req_valid,
  input  logic              req_add_mode,
  input  logic [NTAGS-1:0]  req_excl,
  input  logic [TAG_W-1:0]  req_tag,
  input  logic [TAG_W-1:0]  req_ofs,
  output logic              busy,
  output logic              done,
  output logic [TAG_W-1:0]  res_tag,
  output logic [WORD_W-1:0] st_word
);
  import tagpick_pkg::*;

  logic [SEED_W-1:0] seed_q, seed_d, pend_q, seed_use, lf_seed;
  logic [TAG_W-1:0]  start_q, start_d, lf_ofs;
  tp_mode_e          mode_q;
  logic              accept, st_en, fin_now;
  logic [TAG_W-1:0]  tag_now, ld_tag, ld_ofs;
  logic [NTAGS-1:0]  ld_mask, cur_mask;

  assign seed_use = (seed_q == '0 && ctl_reseed_en) ? SEED_W'(1) : seed_q;

  tagpick_lfsr #(.SEED_W(SEED_W), .STEPS(TAG_W)) i_lfsr (
    .seed_in (seed_use),
    .seed_out(lf_seed),
    .ofs     (lf_ofs)
  );

  assign accept  = req_valid && !busy;
  assign ld_tag  = req_add_mode ? req_tag  : start_q;
  assign ld_ofs  = req_add_mode ? req_ofs  : lf_ofs;
  assign ld_mask = req_add_mode ? ctl_excl : (ctl_excl | req_excl);

  tagpick_walker #(.TAG_W(TAG_W)) i_walk (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (accept),
    .ld_tag  (ld_tag),
    .ld_ofs  (ld_ofs),
    .ld_mask (ld_mask),
    .busy    (busy),
    .fin_now (fin_now),
    .tag_now (tag_now),
    .fin     (done),
    .fin_tag (res_tag),
    .cur_mask(cur_mask)
  );

  always_comb begin
    st_en   = 1'b0;
    seed_d  = seed_q;
    start_d = start_q;
    if (cfg_wr_en) begin
      st_en   = 1'b1;
      seed_d  = cfg_wr_seed;
      start_d = cfg_wr_start;
    end else if (fin_now && mode_q == TP_RAND) begin
      st_en   = 1'b1;
      seed_d  = pend_q;
      start_d = tag_now;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seed_q  <= RST_SEED;
      start_q <= RST_START;
      pend_q  <= '0;
      mode_q  <= TP_RAND;
    end else begin
      if (st_en) begin
        seed_q  <= seed_d;
        start_q <= start_d;
      end
      if (accept) begin
        pend_q <= lf_seed;
        mode_q <= req_add_mode ? TP_ADD : TP_RAND;
      end
    end
  end

  assign st_word = {seed_q, {(8 - TAG_W){1'b0}}, start_q};
endmodule

// File: rtl/tagpick_chk.sv
module tagpick_chk #(
  parameter int TAG_W  = 4,
  parameter int SEED_W = 16
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   busy,
  input logic                   done,
  input logic [TAG_W-1:0]       res_tag,
  input logic [SEED_W+7:0]      st_word,
  input logic                   cfg_wr_en,
  input logic [SEED_W-1:0]      cfg_wr_seed,
  input logic [TAG_W-1:0]       cfg_wr_start,
  input logic [(1<<TAG_W)-1:0]  cur_mask,
  input logic                   mode_add
);
  assert_done_after_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(busy));

  assert_result_allowed_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !(&cur_mask)) |-> !cur_mask[res_tag]);

  assert_all_excluded_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (&cur_mask)) |-> res_tag == '0);

  assert_add_keeps_state_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && mode_add && !$past(cfg_wr_en)) |-> $stable(st_word));

  assert_rand_writeback_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !mode_add && !$past(cfg_wr_en)) |-> st_word[TAG_W-1:0] == res_tag);

  assert_sw_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cfg_wr_en) |-> (st_word[SEED_W+7:8] == $past(cfg_wr_seed) &&
                          st_word[TAG_W-1:0] == $past(cfg_wr_start)));
endmodule

bind tagpick_unit tagpick_chk #(.TAG_W(TAG_W), .SEED_W(SEED_W)) i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .busy        (busy),
  .done        (done),
  .res_tag     (res_tag),
  .st_word     (st_word),
  .cfg_wr_en   (cfg_wr_en),
  .cfg_wr_seed (cfg_wr_seed),
  .cfg_wr_start(cfg_wr_start),
  .cur_mask    (cur_mask),
  .mode_add    (mode_q == tagpick_pkg::TP_ADD)
);

// File: tb/test_tagpick_unit.sv
module test_tagpick_unit;
  localparam logic [15:0] RSEED  = 16'hACE1;
  localparam logic [3:0]  RSTART = 4'h0;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] ctl_excl = '0;
  logic        ctl_reseed_en = 1'b0;
  logic        cfg_wr_en = 1'b0;
  logic [15:0] cfg_wr_seed = '0;
  logic [3:0]  cfg_wr_start = '0;
  logic        req_valid = 1'b0;
  logic        req_add_mode = 1'b0;
  logic [15:0] req_excl = '0;
  logic [3:0]  req_tag = '0;
  logic [3:0]  req_ofs = '0;
  logic        busy, done;
  logic [3:0]  res_tag;
  logic [23:0] st_word;

  tagpick_unit #(.RST_SEED(RSEED), .RST_START(RSTART)) i_tagpick_unit (
    .clk(clk), .rst_n(rst_n), .ctl_excl(ctl_excl), .ctl_reseed_en(ctl_reseed_en),
    .cfg_wr_en(cfg_wr_en), .cfg_wr_seed(cfg_wr_seed), .cfg_wr_start(cfg_wr_start),
    .req_valid(req_valid), .req_add_mode(req_add_mode), .req_excl(req_excl),
    .req_tag(req_tag), .req_ofs(req_ofs), .busy(busy), .done(done),
    .res_tag(res_tag), .st_word(st_word)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit ended = 1'b0;
  logic [15:0] m_seed;
  logic [3:0]  m_start;
  logic [3:0]  exp_q [$];
  int          req_q [$];

  function automatic logic [19:0] m_lfsr(input logic [15:0] s);
    logic [3:0] o;
    for (int i = 0; i < 4; i++) begin
      logic b;
      b = s[5] ^ s[3] ^ s[2] ^ s[0];
      s = {b, s[15:1]};
      o[i] = b;
    end
    return {s, o};
  endfunction

  function automatic logic [3:0] m_pick(input logic [3:0] st, input logic [3:0] of,
                                        input logic [15:0] mk);
    logic [3:0] t;
    if (mk == 16'hFFFF) return 4'h0;
    t = st;
    if (of == 0) begin
      for (int k = 0; k < 16 && mk[t]; k++) t = t + 1'b1;
    end else begin
      for (int n = 0; n < of; n++) begin
        t = t + 1'b1;
        for (int k = 0; k < 16 && mk[t]; k++) t = t + 1'b1;
      end
    end
    return t;
  endfunction

  task automatic check(input bit ok, input int rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL R%0d %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  // prediction for a request; updates the model state for random mode
  task automatic predict(input logic add, input logic [15:0] rx, input logic [3:0] rt,
                         input logic [3:0] ro, output logic [3:0] exp, output logic [3:0] of);
    logic [15:0] su;
    logic [19:0] lf;
    if (add) begin
      of  = ro;
      exp = m_pick(rt, ro, ctl_excl);
    end else begin
      su  = (m_seed == 0 && ctl_reseed_en) ? 16'd1 : m_seed;
      lf  = m_lfsr(su);
      of  = lf[3:0];
      exp = m_pick(m_start, of, ctl_excl | rx);
      m_start = exp;
      m_seed  = lf[19:4];
    end
  endtask

  task automatic issue(input logic add, input logic [15:0] rx, input logic [3:0] rt,
                       input logic [3:0] ro, input int rq);
    logic [3:0] e, of;
    while (busy) @(negedge clk);
    predict(add, rx, rt, ro, e, of);
    exp_q.push_back(e);
    req_q.push_back(rq);
    req_valid = 1'b1; req_add_mode = add; req_excl = rx; req_tag = rt; req_ofs = ro;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic drain();
    @(negedge clk);
    while (busy || exp_q.size() != 0) @(negedge clk);
  endtask

  task automatic chk_state(input int rq);
    check(st_word == {m_seed, 4'h0, m_start}, rq, "state word", st_word, {m_seed, 4'h0, m_start});
  endtask

  task automatic sw_write(input logic [15:0] s, input logic [3:0] t);
    cfg_wr_en = 1'b1; cfg_wr_seed = s; cfg_wr_start = t;
    @(negedge clk);
    cfg_wr_en = 1'b0;
    m_seed = s; m_start = t;
  endtask

  // monitor: compare every result against the scoreboard
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (exp_q.size() == 0) begin
        check(1'b0, 11, "unexpected done pulse", {28'h0, res_tag}, 32'h0);
      end else begin
        logic [3:0] e;
        int rq;
        e  = exp_q.pop_front();
        rq = req_q.pop_front();
        check(res_tag == e, rq, "result tag", {28'h0, res_tag}, {28'h0, e});
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!ended) begin
      ended = 1'b1;
      errors++;
      $display("FAIL R11 watchdog expired actual=1 expected=0");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    m_seed = RSEED;
    m_start = RSTART;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(st_word == {RSEED, 4'h0, RSTART}, 1, "reset state", st_word, {RSEED, 4'h0, RSTART});
    check(busy == 1'b0 && done == 1'b0, 1, "reset busy/done", {busy, done}, 0);

    // R2 R7: random requests without exclusion
    for (int i = 0; i < 4; i++) begin
      issue(1'b0, 16'h0000, 4'h0, 4'h0, 2);
      drain();
      chk_state(7);
    end

    // R3: per-request and control masks combine
    issue(1'b0, 16'h00F0, 4'h0, 4'h0, 3);
    drain(); chk_state(3);
    ctl_excl = 16'h0F0F;
    issue(1'b0, 16'h3000, 4'h0, 4'h0, 3);
    drain(); chk_state(3);
    ctl_excl = 16'h0000;

    // R4: every tag excluded gives tag 0
    ctl_excl = 16'hFFFF;
    issue(1'b0, 16'h0000, 4'h0, 4'h0, 4);
    drain(); chk_state(4);
    issue(1'b1, 16'h0000, 4'h9, 4'h7, 4);
    drain();
    ctl_excl = 16'h0000;

    // R5: offset 0, start allowed, start excluded, wrap past 15
    ctl_excl = 16'h0040;
    issue(1'b1, 16'h0000, 4'h3, 4'h0, 5);
    issue(1'b1, 16'h0000, 4'h6, 4'h0, 5);
    ctl_excl = 16'hC001;
    issue(1'b1, 16'h0000, 4'hE, 4'h0, 5);
    drain();

    // R6: offset N with skipping and wrap
    ctl_excl = 16'h5A5A;
    issue(1'b1, 16'h0000, 4'h1, 4'h5, 6);
    issue(1'b1, 16'h0000, 4'hF, 4'h3, 6);
    drain();

    // R9: add mode ignores req_excl and keeps the state word
    ctl_excl = 16'h0000;
    issue(1'b1, 16'hFFFF, 4'h4, 4'h2, 9);
    drain(); chk_state(9);

    // R8: zero seed, reseed enabled then disabled
    sw_write(16'h0000, 4'h5);
    ctl_reseed_en = 1'b1;
    issue(1'b0, 16'h0000, 4'h0, 4'h0, 8);
    drain(); chk_state(8);
    sw_write(16'h0000, 4'h5);
    ctl_reseed_en = 1'b0;
    issue(1'b0, 16'h0020, 4'h0, 4'h0, 8);
    drain(); chk_state(8);

    // R10: plain software write
    sw_write(16'h1234, 4'hB);
    chk_state(10);

    // R10: software write in the write-back cycle wins
    begin
      logic [3:0] e, of;
      int n;
      while (busy) @(negedge clk);
      predict(1'b0, 16'h0000, 4'h0, 4'h0, e, of);
      n = (of == 0) ? 1 : int'(of);
      exp_q.push_back(e);
      req_q.push_back(10);
      req_valid = 1'b1; req_add_mode = 1'b0; req_excl = '0;
      @(negedge clk);
      req_valid = 1'b0;
      repeat (n - 1) @(negedge clk);
      sw_write(16'hBEEF, 4'h2);
      drain();
      chk_state(10);
    end

    // R11: longest walk, requests raised while busy are ignored
    begin
      int cnt = 0;
      ctl_excl = 16'h7FFF;
      issue(1'b1, 16'h0000, 4'hF, 4'hF, 11);
      while (busy) begin
        cnt++;
        req_valid = (cnt <= 5); req_add_mode = 1'b0; req_excl = 16'h0001;
        @(negedge clk);
      end
      req_valid = 1'b0;
      check(cnt == 240, 11, "busy cycles of longest walk", cnt, 240);
      drain();
      chk_state(11);
      ctl_excl = 16'h0000;
    end

    // R2 R3 R6 R7: mixed stream of random requests
    for (int i = 0; i < 30; i++) begin
      ctl_excl = 16'($urandom) & 16'h9249;
      issue(1'b0, 16'($urandom) & 16'h2424, 4'h0, 4'h0, 6);
    end
    drain();
    chk_state(7);

    ended = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule